// File: doc/BRIEF.md
# Three-Port Parallel I/O Register Block

This block sits between a CPU bus and three 8-bit parallel ports, called A, B and C, where C is split into an upper and a lower 4-bit half. The CPU selects one of four locations with a 2-bit address and reads or writes it through an 8-bit data bus gated by chip select and active-low read and write strobes. One location holds a configuration word. That word sets an operating mode for each of two groups and a direction for each of the four port sections. Group A owns port A and the upper half of C. Group B owns port B and the lower half of C.

A write to the configuration location has two meanings, chosen by its top data bit. With the top bit set, the write loads a whole new configuration and clears every output latch. With the top bit clear, the write sets or clears a single bit of port C and leaves the configuration untouched. In the basic mode, output sections drive their latched values. Input sections are read straight from the pins with no latching. The block drives the port latches and per-pin output enables toward the pad logic. It also exports the group mode fields for strobed-handshake logic that lives elsewhere.

The bus is synchronous to `clk`. A write takes effect in the cycle in which the write strobe is first sampled high again while chip select is still low. Reads are combinational and need no clock. The interface is strobe-based, so there is no valid/ready pairing and no back-pressure: every strobed access completes.

Top module: `pario_ctrl`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration word. A read returns the selected item and a write loads it.
- R2: While `rst` is high and after it falls, the configuration reads as 9Bh, every output enable is 0 and every port latch is 0.
- R3: A configuration write with data bit 7 = 1 stores its fields. Bits 6..5 are the group A mode (`grp_a_mode`). Bit 2 is the group B mode (`grp_b_mode`). Direction bits are bit 4 for port A, bit 3 for upper C, bit 1 for port B and bit 0 for lower C, where 1 means input. Each output enable is the inverse of its direction bit.
- R4: A configuration write with data bit 7 = 0 does a single-bit operation on port C. Bits 3..1 give the bit index and bit 0 gives the new value. Bits 6..4 are ignored, and the stored configuration does not change.
- R5: A configuration write with bit 7 = 1 clears the A, B and C latches to 0.
- R6: In the basic mode (mode 0), an output section drives its latch, and a read of that section returns the latch. A read of an input section returns the current pin value in the same cycle.
- R7: A direct write to port C changes a half only when its group is in mode 0 and that half is an output. Any other half keeps its latch value.
- R8: A read of the configuration location returns bit 7 as 1 and bits 6..0 as stored.
- R9: `dout_oe` is 1 only when `cs_n` and `rd_n` are both low. With `cs_n` high, the bus is released.
- R10: A write commits in the cycle where `wr_n` is sampled high after being sampled low, provided `cs_n` is low. While `wr_n` is held low, nothing changes.
- R11: The port latches change only in a cycle in which a write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst | input | 1 | synchronous reset, active high |
| cs_n | input | 1 | chip select, active low |
| rd_n | input | 1 | read strobe, active low |
| wr_n | input | 1 | write strobe, active low |
| addr | input | 2 | location select |
| din | input | 8 | write data from CPU |
| dout | output | 8 | read data to CPU |
| dout_oe | output | 1 | drive enable for the CPU data bus |
| pa_in | input | 8 | port A pin values |
| pb_in | input | 8 | port B pin values |
| pc_in | input | 8 | port C pin values |
| pa_out | output | 8 | port A output latch |
| pb_out | output | 8 | port B output latch |
| pc_out | output | 8 | port C output latch |
| pa_oe | output | 8 | port A per-pin output enable |
| pb_oe | output | 8 | port B per-pin output enable |
| pc_oe | output | 8 | port C per-pin output enable |
| grp_a_mode | output | 2 | group A mode field |
| grp_b_mode | output | 1 | group B mode field |

## Verification
Two things can meet on port C. A single-bit operation on C can land on a half configured as input, and a direct C write can reach a mixed-direction configuration where only one half may change. The bench first sets upper C to input and lower C to output. It then sends a direct C write of all ones and expects only the lower nibble to change. After that it sets bit 7 through a single-bit operation and reads the configuration back to confirm the word is unchanged. A C readback is then checked to merge the pin nibble and the latch nibble in one cycle.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int PW = 8;
  localparam int HW = PW / 2;
  localparam int IW = $clog2(PW);
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } sel_e;
  localparam logic [PW-2:0] CFG_RST = 7'h1B;
endpackage

// File: rtl/pario_bus_sync.sv
module pario_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_fire
);
  logic wr_low_q;

  always_ff @(posedge clk) begin
    if (rst) wr_low_q <= 1'b0;
    else     wr_low_q <= ~wr_n & ~cs_n;
  end

  // rising edge of the write strobe, seen while still selected
  assign wr_fire = wr_low_q & wr_n & ~cs_n;
endmodule

// File: rtl/pario_cfg_word.sv
module pario_cfg_word
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [PW-1:0] din,
  output logic [PW-2:0] cfg_q,
  output logic          mode_load,
  output logic          bit_op
);
  assign mode_load = cfg_wr & din[PW-1];
  assign bit_op    = cfg_wr & ~din[PW-1];

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= CFG_RST;
    else if (mode_load) cfg_q <= din[PW-2:0];
  end
endmodule

// File: rtl/pario_port_regs.sv
module pario_port_regs
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [1:0]    wr_c_half,
  input  logic          bit_op,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] a_q,
  output logic [PW-1:0] b_q,
  output logic [PW-1:0] c_q
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a) a_q <= din;
      if (wr_b) b_q <= din;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_chalf
    for (genvar k = 0; k < HW; k++) begin : g_bit
      localparam int P = h * HW + k;
      always_ff @(posedge clk) begin
        if (rst || clr_all)                       c_q[P] <= 1'b0;
        else if (bit_op && bit_idx == IW'(P))     c_q[P] <= bit_val;
        else if (wr_c_half[h])                    c_q[P] <= din[P];
      end
    end
  end
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  output logic          dout_oe,
  input  logic [PW-1:0] pa_in,
  input  logic [PW-1:0] pb_in,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pa_oe,
  output logic [PW-1:0] pb_oe,
  output logic [PW-1:0] pc_oe,
  output logic [1:0]    grp_a_mode,
  output logic          grp_b_mode
);
  logic          wr_fire, mode_load, bit_op;
  logic [PW-2:0] cfg_q;
  logic [1:0]    wr_c_half;
  sel_e          sel;

  assign sel = sel_e'(addr);

  pario_bus_sync u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .wr_fire(wr_fire)
  );

  pario_cfg_word u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(wr_fire && sel == SEL_CFG), .din(din),
    .cfg_q(cfg_q), .mode_load(mode_load), .bit_op(bit_op)
  );

  assign grp_a_mode = cfg_q[6:5];
  assign grp_b_mode = cfg_q[2];
  assign pa_oe = {PW{~cfg_q[4]}};
  assign pb_oe = {PW{~cfg_q[1]}};
  assign pc_oe = {{HW{~cfg_q[3]}}, {HW{~cfg_q[0]}}};

  // direct C writes reach only mode-0 output halves
  assign wr_c_half[1] = wr_fire && sel == SEL_C && cfg_q[6:5] == 2'b00 && !cfg_q[3];
  assign wr_c_half[0] = wr_fire && sel == SEL_C && !cfg_q[2] && !cfg_q[0];

  pario_port_regs u_regs (
    .clk(clk), .rst(rst), .clr_all(mode_load),
    .wr_a(wr_fire && sel == SEL_A), .wr_b(wr_fire && sel == SEL_B),
    .wr_c_half(wr_c_half), .bit_op(bit_op), .bit_idx(din[IW:1]),
    .bit_val(din[0]), .din(din),
    .a_q(pa_out), .b_q(pb_out), .c_q(pc_out)
  );

  always_comb begin
    unique case (sel)
      SEL_A:   dout = (pa_out & pa_oe) | (pa_in & ~pa_oe);
      SEL_B:   dout = (pb_out & pb_oe) | (pb_in & ~pb_oe);
      SEL_C:   dout = (pc_out & pc_oe) | (pc_in & ~pc_oe);
      default: dout = {1'b1, cfg_q};
    endcase
  end

  assign dout_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/pario_ctrl_chk.sv
module pario_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic [1:0] addr,
  input logic [7:0] din,
  input logic       dout_oe,
  input logic       wr_fire,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe
);
  p_bus_release_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dout_oe);

  p_mode_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && din[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  p_dir_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && din[7]) |=> (pa_oe == {8{~$past(din[4])}} && pb_oe == {8{~$past(din[1])}}));

  p_bitop_keeps_cfg_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && !din[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_hold_latches_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  p_c_input_half_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd2) |=> ((pc_out & ~$past(pc_oe)) == ($past(pc_out) & ~$past(pc_oe))));
endmodule

bind pario_ctrl pario_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .din(din),
  .dout_oe(dout_oe), .wr_fire(wr_fire), .pa_out(pa_out), .pb_out(pb_out),
  .pc_out(pc_out), .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/tb_pario_ctrl.sv
module tb_pario_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] dout, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;
  logic       dout_oe, grp_b_mode;
  logic [1:0] grp_a_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [7:0] exp; } rd_item_t;
  rd_item_t sb[$];

  always #2 clk = ~clk;

  pario_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .pa_in(pa_in), .pb_in(pb_in),
    .pc_in(pc_in), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe), .grp_a_mode(grp_a_mode),
    .grp_b_mode(grp_b_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_read(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_item_t it;
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    it.tag = tag; it.exp = exp; sb.push_back(it);
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  // monitor: pops expectations while a read is on the bus
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!cs_n && !rd_n && sb.size() > 0) begin
        rd_item_t it;
        it = sb.pop_front();
        check({it.tag, " dout_oe"}, {7'd0, dout_oe}, 8'd1);
        check(it.tag, dout, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check("R2 pa_oe", pa_oe, 8'h00);
    check("R2 pc_oe", pc_oe, 8'h00);
    check("R2 pc_out", pc_out, 8'h00);
    bus_read("R2 R8 cfg after reset", 2'd3, 8'h9B);

    // R3: all outputs, mode 0
    bus_write(2'd3, 8'h80);
    @(negedge clk);
    check("R3 pa_oe", pa_oe, 8'hFF);
    check("R3 pc_oe", pc_oe, 8'hFF);
    bus_read("R8 cfg 80", 2'd3, 8'h80);

    // R1 R6: write and read back
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h96);
    @(negedge clk);
    check("R1 R6 pa_out", pa_out, 8'h5A);
    check("R1 R6 pb_out", pb_out, 8'hC3);
    check("R1 R6 pc_out", pc_out, 8'h96);
    bus_read("R1 read A", 2'd0, 8'h5A);
    bus_read("R1 read B", 2'd1, 8'hC3);

    // R10 R11: held strobe does not commit
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; din = 8'h11; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 R11 held low", pa_out, 8'h5A);
    wr_n = 1'b1;
    @(negedge clk);
    check("R10 commit on release", pa_out, 8'h11);
    cs_n = 1'b1;

    // R5 R7: upper C input, lower C output
    bus_write(2'd3, 8'h88);
    @(negedge clk);
    check("R5 cleared A", pa_out, 8'h00);
    check("R3 pc_oe mixed", pc_oe, 8'h0F);
    bus_write(2'd2, 8'hFF);
    @(negedge clk);
    check("R7 only lower half", pc_out, 8'h0F);
    pc_in = 8'hA5;
    bus_read("R6 C merge", 2'd2, 8'hAF);

    // R4: bit op sets bit 7 and clears bit 1 (bits 6..4 set, ignored)
    bus_write(2'd3, 8'h0F);
    bus_write(2'd3, 8'h72);
    @(negedge clk);
    check("R4 bit ops", pc_out, 8'h8D);
    bus_read("R4 cfg unchanged", 2'd3, 8'h88);

    // R6: input port passes pins without latching
    bus_write(2'd3, 8'h92);
    pa_in = 8'h3C;
    bus_read("R6 A pin", 2'd0, 8'h3C);
    pa_in = 8'hE1;
    bus_read("R6 A pin changed", 2'd0, 8'hE1);

    // R3 R7: non-zero modes block direct C writes
    bus_write(2'd3, 8'hE4);
    @(negedge clk);
    check("R3 grp_a_mode", {6'd0, grp_a_mode}, 8'h03);
    check("R3 grp_b_mode", {7'd0, grp_b_mode}, 8'h01);
    bus_write(2'd2, 8'hFF);
    @(negedge clk);
    check("R7 mode not 0", pc_out, 8'h00);

    // R9: no chip select, bus released
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    #1 check("R9 released", {7'd0, dout_oe}, 8'h00);
    @(negedge clk); rd_n = 1'b1;

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", 8'(sb.size()), 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule